// File: doc/BRIEF.md
# Multi-Cycle Priority Interrupt Arbiter

This block is the interrupt controller for a single service provider. A set of request nodes each present a pending flag and an 8-bit priority number. The arbiter picks the highest priority among them. It does this over several arbitration rounds, and each round compares one 2-bit slice of the priority numbers, most significant relevant slice first. Software can program how many rounds are run (one to four) and how many clocks each round takes (one or two). Fewer rounds shorten the time from a request to a decision, but they also narrow the usable priority range, because bits above the rounds in use are ignored.

The winner appears as the pending priority in a control word, next to the global enable, the current CPU priority and the two timing fields. An interrupt goes to the CPU when the global enable is set and the pending priority is above the current priority. The CPU accepts through a valid/ready style handshake: `irq_out` is the valid, `irq_ack` is the ready, and the transfer happens on a clock edge where both are high. `irq_out` stays up until it is accepted or until its condition goes away. It is not latched. When an accept happens, the hardware clears the enable, raises the current priority to the winner's, and sends a one-cycle acknowledge pulse to the winning node.

Top module: `irqa_top`

## Requirements
- R1: After reset the control word reads 0x00000000, and `irq_out` and `ack_node` are low.
- R2: The control word layout is: bit 26 one-clock mode, bits 25:24 round-count select, bits 23:16 pending priority (read-only), bit 8 global enable, bits 7:0 current priority. All other bits read 0 and ignore writes. A write to bits 23:16 has no effect.
- R3: Round-count select 00/01/10/11 runs 4/3/2/1 rounds. Only priority bits 7:0, 5:0, 3:0 or 1:0 take part in arbitration, in that order. The pending priority is reported with the ignored bits cleared, and a request whose relevant bits are all zero never wins.
- R4: Bit 26 = 0 gives two clocks per round and bit 26 = 1 gives one. After a change, the pending priority reads 0 for 1 + C·K clock edges and holds the result from edge 2 + C·K on. Here C is the clocks per round, K is the number of rounds, and the change edge counts as the first edge.
- R5: The pending priority is the largest relevant priority among pending requests, or 0 when there is none. When requests tie, the lowest-numbered node wins.
- R6: `irq_out` is high exactly when the enable is 1 and the pending priority is strictly greater than the current priority. A higher request can therefore preempt a routine that is already running, but an equal or lower one cannot.
- R7: On an accepted request, the enable goes to 0, the current priority takes the pending priority, and `ack_node` is one-hot on the winner for exactly one cycle after the accepting edge.
- R8: When an accept and a software write fall on the same edge, the accept decides the enable and the current priority. The write still sets the bit 26 and bits 25:24 fields.
- R9: A change in the pending flags, in any priority number, or in the bits 26:24 fields starts a new arbitration. A write that leaves those fields unchanged does not.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_pend | input | N_SRC | Pending flag per request node |
| req_prio | input | 8·N_SRC | Priority number per node, node i in bits 8i+7:8i |
| wr_en | input | 1 | Control word write strobe |
| wr_data | input | 32 | Control word write value |
| ctrl_rd | output | 32 | Control word read value |
| irq_out | output | 1 | Interrupt request to the CPU (valid) |
| irq_ack | input | 1 | CPU accepts the request (ready) |
| ack_node | output | N_SRC | One-cycle one-hot acknowledge to the winning node |

## Verification
Two updates can land on one clock edge: the CPU accepting an interrupt and software writing the control word. The bench provokes this by raising `irq_ack` and `wr_en` together, with a write value that sets the enable and zeroes the current priority. It then expects the enable at 0, the current priority equal to the accepted winner, and the winner's acknowledge pulse in the scoreboard. The same edge also lines up an accept with the drop of the winning node's pending flag, and the next arbitration must then report the remaining highest request.

// File: rtl/irqa_pkg.sv
package irqa_pkg;
  localparam int PRIO_W = 8;
  localparam int SLICE_W = 2;

  typedef struct packed {
    logic             one_clk;
    logic [1:0]       rnd_sel;
    logic             ie;
    logic [PRIO_W-1:0] cur;
  } ctrl_t;

  // relevant priority bits for a round-count select
  function automatic logic [PRIO_W-1:0] prio_mask(input logic [1:0] sel);
    return PRIO_W'(8'hFF >> (2 * int'(sel)));
  endfunction
endpackage

// File: rtl/irqa_ctrl_reg.sv
module irqa_ctrl_reg
  import irqa_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [2:0]        wr_timing,
  input  logic              wr_ie,
  input  logic [PRIO_W-1:0] wr_cur,
  input  logic              ack_fire,
  input  logic [PRIO_W-1:0] ack_prio,
  output ctrl_t             cfg,
  output logic              cfg_restart
);
  assign cfg_restart = wr_en && (wr_timing != {cfg.one_clk, cfg.rnd_sel});

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg <= '0;
    end else begin
      if (wr_en) begin
        cfg.one_clk <= wr_timing[2];
        cfg.rnd_sel <= wr_timing[1:0];
      end
      if (ack_fire) begin
        cfg.ie  <= 1'b0;
        cfg.cur <= ack_prio;
      end else if (wr_en) begin
        cfg.ie  <= wr_ie;
        cfg.cur <= wr_cur;
      end
    end
  end
endmodule

// File: rtl/irqa_slice_cmp.sv
module irqa_slice_cmp
  import irqa_pkg::*;
#(
  parameter int N_SRC = 8
) (
  input  logic [N_SRC-1:0]        cand,
  input  logic [N_SRC*PRIO_W-1:0] prio_flat,
  input  logic [1:0]              slice_idx,
  output logic [N_SRC-1:0]        keep
);
  logic [SLICE_W-1:0] sl  [N_SRC];
  logic [SLICE_W-1:0] top;

  always_comb begin
    for (int i = 0; i < N_SRC; i++)
      sl[i] = prio_flat[i*PRIO_W + SLICE_W*int'(slice_idx) +: SLICE_W];
    top = '0;
    for (int i = 0; i < N_SRC; i++)
      if (cand[i] && sl[i] > top) top = sl[i];
    for (int i = 0; i < N_SRC; i++)
      keep[i] = cand[i] && (sl[i] == top);
  end
endmodule

// File: rtl/irqa_seq.sv
module irqa_seq
  import irqa_pkg::*;
#(
  parameter int N_SRC = 8,
  localparam int IW = (N_SRC > 1) ? $clog2(N_SRC) : 1
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [N_SRC-1:0]        req_pend,
  input  logic [N_SRC*PRIO_W-1:0] req_prio,
  input  logic [1:0]              rnd_sel,
  input  logic                    one_clk,
  input  logic                    cfg_restart,
  output logic [PRIO_W-1:0]       pend_prio,
  output logic [IW-1:0]           win_idx
);
  typedef enum logic [1:0] {S_IDLE, S_LOAD, S_ARB} st_t;

  st_t                     st;
  logic [N_SRC-1:0]        pend_q, cand, keep;
  logic [N_SRC*PRIO_W-1:0] prio_q;
  logic [1:0]              slice;
  logic                    phase;
  logic [PRIO_W-1:0]       mprio [N_SRC];
  logic [IW-1:0]           win_n;
  logic [PRIO_W-1:0]       wp_n;
  logic                    found;
  logic                    change;

  assign change = cfg_restart || (req_pend != pend_q) || (req_prio != prio_q);

  always_comb begin
    for (int i = 0; i < N_SRC; i++)
      mprio[i] = prio_q[i*PRIO_W +: PRIO_W] & prio_mask(rnd_sel);
  end

  irqa_slice_cmp #(.N_SRC(N_SRC)) u_cmp (
    .cand(cand), .prio_flat(prio_q), .slice_idx(slice), .keep(keep)
  );

  always_comb begin
    win_n = '0;
    wp_n  = '0;
    found = 1'b0;
    for (int i = 0; i < N_SRC; i++) begin
      if (keep[i] && !found) begin
        found = 1'b1;
        win_n = IW'(i);
        wp_n  = mprio[i];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE; pend_q <= '0; prio_q <= '0; cand <= '0;
      slice <= '0; phase <= 1'b0; pend_prio <= '0; win_idx <= '0;
    end else if (change) begin
      pend_q    <= req_pend;
      prio_q    <= req_prio;
      pend_prio <= '0;
      st        <= S_LOAD;
    end else begin
      case (st)
        S_LOAD: begin
          for (int i = 0; i < N_SRC; i++)
            cand[i] <= pend_q[i] && (mprio[i] != '0);
          slice <= 2'd3 - rnd_sel;
          phase <= 1'b0;
          st    <= S_ARB;
        end
        S_ARB: begin
          if (one_clk || phase) begin
            cand  <= keep;
            phase <= 1'b0;
            if (slice == 2'd0) begin
              pend_prio <= wp_n;
              win_idx   <= win_n;
              st        <= S_IDLE;
            end else begin
              slice <= slice - 2'd1;
            end
          end else begin
            phase <= 1'b1;
          end
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/irqa_top.sv
module irqa_top
  import irqa_pkg::*;
#(
  parameter int N_SRC = 8,
  localparam int IW = (N_SRC > 1) ? $clog2(N_SRC) : 1
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [N_SRC-1:0]        req_pend,
  input  logic [N_SRC*PRIO_W-1:0] req_prio,
  input  logic                    wr_en,
  input  logic [31:0]             wr_data,
  output logic [31:0]             ctrl_rd,
  output logic                    irq_out,
  input  logic                    irq_ack,
  output logic [N_SRC-1:0]        ack_node
);
  ctrl_t             cfg;
  logic              cfg_restart;
  logic [PRIO_W-1:0] pend_prio;
  logic [IW-1:0]     win_idx;
  logic              ack_fire;
  logic              unused_wr_bits;

  assign unused_wr_bits = ^{wr_data[31:27], wr_data[23:9]};
  assign irq_out  = cfg.ie && (pend_prio > cfg.cur);
  assign ack_fire = irq_out && irq_ack;
  assign ctrl_rd  = {5'b0, cfg.one_clk, cfg.rnd_sel, pend_prio, 7'b0, cfg.ie, cfg.cur};

  irqa_ctrl_reg u_reg (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en),
    .wr_timing(wr_data[26:24]), .wr_ie(wr_data[8]), .wr_cur(wr_data[7:0]),
    .ack_fire(ack_fire), .ack_prio(pend_prio),
    .cfg(cfg), .cfg_restart(cfg_restart)
  );

  irqa_seq #(.N_SRC(N_SRC)) u_seq (
    .clk(clk), .rst_n(rst_n), .req_pend(req_pend), .req_prio(req_prio),
    .rnd_sel(cfg.rnd_sel), .one_clk(cfg.one_clk), .cfg_restart(cfg_restart),
    .pend_prio(pend_prio), .win_idx(win_idx)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        ack_node <= '0;
    else if (ack_fire) ack_node <= {{(N_SRC-1){1'b0}}, 1'b1} << win_idx;
    else               ack_node <= '0;
  end
endmodule

// File: rtl/irqa_chk.sv
module irqa_chk #(
  parameter int N_SRC = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic [N_SRC-1:0] req_pend,
  input logic             irq_out,
  input logic             irq_ack,
  input logic [N_SRC-1:0] ack_node,
  input logic [31:0]      ctrl_rd
);
  a_r7_ack_onehot: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(ack_node));

  a_r7_ack_single: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_node != '0) |=> (ack_node == '0));

  a_r7_ack_update: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_out && irq_ack) |=> (!ctrl_rd[8] && ctrl_rd[7:0] == $past(ctrl_rd[23:16]) && ack_node != '0));

  a_r9_restart_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (req_pend != $past(req_pend)) |=> (ctrl_rd[23:16] == 8'h00));

  a_r6_no_irq_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_rd[23:16] == 8'h00 || !ctrl_rd[8]) |-> !irq_out);

  a_r2_reserved_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_rd[31:27] == 5'b0 && ctrl_rd[15:9] == 7'b0));
endmodule

bind irqa_top irqa_chk #(.N_SRC(N_SRC)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_pend(req_pend), .irq_out(irq_out),
  .irq_ack(irq_ack), .ack_node(ack_node), .ctrl_rd(ctrl_rd)
);

// File: tb/test_irqa_top.sv
module test_irqa_top;
  localparam int CLK_P = 10;
  localparam int N = 8;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic [N-1:0]    req_pend = '0;
  logic [N*8-1:0]  req_prio = '0;
  logic            wr_en = 1'b0;
  logic [31:0]     wr_data = '0;
  logic [31:0]     ctrl_rd;
  logic            irq_out;
  logic            irq_ack = 1'b0;
  logic [N-1:0]    ack_node;

  int n_chk = 0;
  int n_bad = 0;
  int exp_q[$];

  always #(CLK_P/2) clk = ~clk;

  irqa_top #(.N_SRC(N)) i_irqa_top (
    .clk(clk), .rst_n(rst_n), .req_pend(req_pend), .req_prio(req_prio),
    .wr_en(wr_en), .wr_data(wr_data), .ctrl_rd(ctrl_rd),
    .irq_out(irq_out), .irq_ack(irq_ack), .ack_node(ack_node)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic set_src(input int i, input logic [7:0] p);
    req_prio[i*8 +: 8] = p;
    req_pend[i] = 1'b1;
  endtask

  task automatic wr(input logic [31:0] d);
    wr_en = 1'b1; wr_data = d;
    step(1);
    wr_en = 1'b0;
  endtask

  // driver: push the expected winner, then hand over the accept
  task automatic accept(input int node);
    exp_q.push_back(node);
    irq_ack = 1'b1;
    step(1);
    irq_ack = 1'b0;
  endtask

  // monitor: every acknowledge pulse is compared against the queue
  always @(negedge clk) begin
    if (rst_n && ack_node != '0) begin
      if (exp_q.size() == 0) begin
        chk("R7 unexpected ack", 32'(ack_node), 32'h0);
      end else begin
        chk("R5/R7 ack winner", 32'(ack_node), 32'(1) << exp_q.pop_front());
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog act=hung exp=done");
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    step(3);
    chk("R1 ctrl reset", ctrl_rd, 32'h0);
    chk("R1 irq reset", 32'(irq_out), 32'h0);
    chk("R1 ack reset", 32'(ack_node), 32'h0);
    rst_n = 1'b1;
    step(1);

    // default timing: 4 rounds, 2 clocks each -> result on edge 10
    set_src(2, 8'h35); set_src(5, 8'h7A); set_src(6, 8'h12);
    step(9);
    chk("R9 zero while arbitrating", 32'(ctrl_rd[23:16]), 32'h00);
    step(1);
    chk("R4 R5 full range result", 32'(ctrl_rd[23:16]), 32'h7A);
    chk("R6 disabled no irq", 32'(irq_out), 32'h0);

    wr(32'h0000_017A);
    chk("R9 same timing no restart", 32'(ctrl_rd[23:16]), 32'h7A);
    chk("R6 equal prio no irq", 32'(irq_out), 32'h0);
    wr(32'h0000_0179);
    chk("R6 higher prio irq", 32'(irq_out), 32'h1);

    accept(5);
    chk("R7 enable cleared", 32'(ctrl_rd[8]), 32'h0);
    chk("R7 current loaded", 32'(ctrl_rd[7:0]), 32'h7A);
    chk("R7 irq drops", 32'(irq_out), 32'h0);
    req_pend[5] = 1'b0;
    step(1);
    chk("R7 ack one cycle", 32'(ack_node), 32'h0);
    step(8);
    chk("R9 rerun zero", 32'(ctrl_rd[23:16]), 32'h00);
    step(1);
    chk("R5 next highest", 32'(ctrl_rd[23:16]), 32'h35);

    // nesting: lower stays quiet, higher preempts
    wr(32'h0000_017A);
    chk("R6 lower no preempt", 32'(irq_out), 32'h0);
    set_src(7, 8'h90);
    step(10);
    chk("R6 higher preempts", 32'(irq_out), 32'h1);

    // accept and software write on the same edge
    req_pend[7] = 1'b0;
    exp_q.push_back(7);
    irq_ack = 1'b1; wr_en = 1'b1; wr_data = 32'h0000_0100;
    step(1);
    irq_ack = 1'b0; wr_en = 1'b0;
    chk("R8 enable from accept", 32'(ctrl_rd[8]), 32'h0);
    chk("R8 current from accept", 32'(ctrl_rd[7:0]), 32'h90);
    step(9);
    chk("R5 after drop", 32'(ctrl_rd[23:16]), 32'h35);

    // one round, one clock: only bits 1:0 count
    req_pend = '0;
    set_src(1, 8'h07); set_src(2, 8'h35); set_src(3, 8'h41);
    wr_en = 1'b1; wr_data = 32'h0700_0000;
    step(1);
    wr_en = 1'b0;
    step(1);
    chk("R4 one round not yet", 32'(ctrl_rd[23:16]), 32'h00);
    step(1);
    chk("R3 masked to 2 bits", 32'(ctrl_rd[23:16]), 32'h03);
    wr(32'h0700_0100);
    chk("R6 irq 1-round", 32'(irq_out), 32'h1);
    accept(1);
    chk("R7 current 1-round", 32'(ctrl_rd[7:0]), 32'h03);

    // two rounds, one clock: bits 3:0, tie -> lowest node
    req_pend = '0;
    set_src(0, 8'hF4); set_src(4, 8'h0C); set_src(7, 8'h1C);
    wr_en = 1'b1; wr_data = 32'h0600_0100;
    step(1);
    wr_en = 1'b0;
    step(2);
    chk("R4 two rounds not yet", 32'(ctrl_rd[23:16]), 32'h00);
    step(1);
    chk("R3 R5 masked tie", 32'(ctrl_rd[23:16]), 32'h0C);
    accept(4);

    // one round, two clocks; relevant bits zero never win
    req_pend = '0;
    set_src(1, 8'h40);
    wr_en = 1'b1; wr_data = 32'h0300_0100;
    step(1);
    wr_en = 1'b0;
    step(3);
    chk("R3 zero relevant bits", 32'(ctrl_rd[23:16]), 32'h00);
    chk("R6 no irq on zero", 32'(irq_out), 32'h0);
    set_src(6, 8'h02);
    step(3);
    chk("R4 two-clock round not yet", 32'(ctrl_rd[23:16]), 32'h00);
    step(1);
    chk("R4 two-clock round result", 32'(ctrl_rd[23:16]), 32'h02);

    // reserved bits and read-only pending field
    wr(32'hFFFF_FFFF);
    chk("R2 layout readback", ctrl_rd & 32'hFF00_FFFF, 32'h0700_01FF);
    chk("R2 pending not written", 32'(ctrl_rd[23:16]), 32'h00);
    step(2);
    chk("R2 pending from arbiter", 32'(ctrl_rd[23:16]), 32'h02);

    step(2);
    chk("R7 scoreboard drained", 32'(exp_q.size()), 32'h0);
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule